// File: doc/BRIEF.md
# Two-Mode Transmit Waveform Generator (NRZI Tone Keying and Scrambled Baseband)

This block produces the sample stream that feeds a small transmit DAC. A baud tick takes the next data bit from the framing logic and NRZI-encodes it into a line symbol. What happens next depends on the mode. In tone mode the symbol picks one of two phase increments for a phase accumulator, and the top bits of that accumulator index a 128-point sine shape. In baseband mode the symbol passes through a self-synchronising scrambler with taps at x^17 and x^12, and the scrambled bit becomes a two-level output.

A separate sample enable advances the accumulator and refreshes the 4-bit DAC code. The accumulator is never reset at a tone change, so the tone waveform stays phase-continuous across symbol boundaries. Three test patterns are available for setting up a transmitter: steady mark, steady space and alternating symbols. During a test pattern no data bits are consumed. The test selection is read only on baud ticks.

Top module: `tone_bb_tx_gen`

## Requirements
- R1: On a baud tick with test code 0 (off), `bit_take` is high in that cycle and `bit_in` is consumed. A 0 inverts the line symbol and a 1 keeps it. The symbol register changes on the clock edge that ends the tick cycle.
- R2: `bit_take` is low in every cycle without a baud tick and on every baud tick with a non-zero test code.
- R3: In baseband mode with test off, each tick sends tx = s ^ r[16] ^ r[11]. Here s is the new NRZI symbol and r is a 17-bit register that resets to all ones. The register then shifts toward its MSB and takes tx into bit 0. The line level becomes tx.
- R4: In tone mode a tick loads the tone select with the new symbol. Symbol 1 selects `space_inc` and symbol 0 selects `mark_inc`. The new selection applies to samples from the next cycle onward.
- R5: Each `sample_en` in tone mode adds the selected increment to a PHASE_W-bit accumulator, modulo 2^PHASE_W. The accumulator is never cleared at a tone change, and it is held while in baseband mode.
- R6: In tone mode the table index is the top 7 accumulator bits, taken before the add. The value at index i < 64 is floor(8 + 7·sin(2πi/128)). The value at index i ≥ 64 is 16 − floor(8 + 7·|sin(2πi/128)|), which keeps every value within 1..15.
- R7: `dac_code` changes only on the edge that ends a `sample_en` cycle, and it holds otherwise. In baseband mode it is 15 for line level 1 and 0 for line level 0.
- R8: On a tick with test code 1 (steady mark) or 2 (steady space), the tone select is forced to mark or space in tone mode. In baseband mode the line level is forced to 0 or 1. The scrambler does not advance.
- R9: On a tick with test code 3 (alternate), tone mode inverts the symbol and loads it into the tone select. Baseband mode inverts the line level directly, without the scrambler.
- R10: After reset, `dac_code` is 8, `bit_take` is 0, the symbol, line level, tone select (mark) and accumulator are 0, and the scrambler register is all ones.
- R11: Changing `test_sel` between baud ticks has no effect on the output until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle symbol-rate strobe |
| sample_en | input | 1 | One-cycle output-rate strobe |
| baseband_mode | input | 1 | 1 selects scrambled two-level output, 0 selects tone keying |
| test_sel | input | 2 | 0 off, 1 steady mark, 2 steady space, 3 alternate |
| mark_inc | input | PHASE_W | Phase increment per sample for the mark tone |
| space_inc | input | PHASE_W | Phase increment per sample for the space tone |
| bit_in | input | 1 | Next data bit, valid when `bit_take` is high |
| bit_take | output | 1 | Data bit consumed in this cycle |
| dac_code | output | 4 | DAC sample code |

## Verification
The bench builds the block with PHASE_W = 12 and increments of 32 and 96. A mark sample then steps the sine index by one and a space sample steps it by three. This makes the 128-entry wrap and a mid-table tone switch easy to reach in a few hundred samples. Runs of one data bit and of mixed data bits drive the scrambler from its all-ones reset, so the scrambled level sequence follows directly from the tap rule. Some baud ticks fall in the same cycle as a sample enable, which tests the ordering of symbol update and sample output.

// File: rtl/tx_gen_pkg.sv
`timescale 1ns/1ps
package tx_gen_pkg;

    localparam int SINE_IDX_W = 7;
    localparam int DAC_W      = 4;

    typedef enum logic [1:0] {
        TST_OFF   = 2'd0,
        TST_MARK  = 2'd1,
        TST_SPACE = 2'd2,
        TST_ALT   = 2'd3
    } tst_e;

    // Level in the rising quarter, k = 0..32 out of 128 steps per period
    function automatic logic [DAC_W-1:0] quarter_level(input logic [5:0] k);
        logic [DAC_W-1:0] v;
        if (k >= 6'd32)      v = 4'd15;
        else if (k >= 6'd21) v = 4'd14;
        else if (k >= 6'd17) v = 4'd13;
        else if (k >= 6'd13) v = 4'd12;
        else if (k >= 6'd10) v = 4'd11;
        else if (k >= 6'd6)  v = 4'd10;
        else if (k >= 6'd3)  v = 4'd9;
        else                 v = 4'd8;
        return v;
    endfunction

    // Full period built from the quarter by mirroring (R6)
    function automatic logic [DAC_W-1:0] sine_level(input logic [SINE_IDX_W-1:0] idx);
        logic [5:0]       p;
        logic [5:0]       k;
        logic [DAC_W-1:0] q;
        logic [DAC_W:0]   neg;
        p   = idx[5:0];
        k   = (p <= 6'd32) ? p : 6'd0 - p;
        q   = quarter_level(k);
        neg = 5'd16 - {1'b0, q};
        return idx[6] ? neg[DAC_W-1:0] : q;
    endfunction

endpackage

// File: rtl/lfsr_scrambler.sv
`timescale 1ns/1ps
module lfsr_scrambler #(
    parameter int LEN    = 17,
    parameter int TAP_HI = 16,
    parameter int TAP_LO = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [LEN-1:0] sh;
    } scr_t;

    scr_t st_d, st_q;

    always_comb begin
        dout = din ^ st_q.sh[TAP_HI] ^ st_q.sh[TAP_LO];
        st_d = st_q;
        if (step) st_d.sh = {st_q.sh[LEN-2:0], dout};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sh: {LEN{1'b1}}};
        else        st_q <= st_d;
    end

    // R3: the sent bit is what enters the register
    assert_feedback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> st_q.sh[0] == $past(dout));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q.sh));

endmodule

// File: rtl/tone_phase_acc.sv
`timescale 1ns/1ps
module tone_phase_acc #(
    parameter int PW = 16,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [PW-1:0] inc,
    output logic [IW-1:0] idx
);
    typedef struct packed {
        logic [PW-1:0] ph;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) st_d.ph = st_q.ph + inc;
        idx = st_q.ph[PW-1 -: IW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: phase only moves on an advance
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.ph));

endmodule

// File: rtl/tone_bb_tx_gen.sv
`timescale 1ns/1ps
module tone_bb_tx_gen
    import tx_gen_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               sample_en,
    input  logic               baseband_mode,
    input  logic [1:0]         test_sel,
    input  logic [PHASE_W-1:0] mark_inc,
    input  logic [PHASE_W-1:0] space_inc,
    input  logic               bit_in,
    output logic               bit_take,
    output logic [DAC_W-1:0]   dac_code
);
    localparam int IW = SINE_IDX_W;
    localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1 << (DAC_W - 1));

    typedef struct packed {
        logic             sym;
        logic             line;
        logic             tone;
        logic [DAC_W-1:0] dac;
    } gen_t;

    gen_t st_d, st_q;

    tst_e              tsel;
    logic              nsym;
    logic              scr_step;
    logic              scr_out;
    logic              acc_adv;
    logic [PHASE_W-1:0] acc_inc;
    logic [IW-1:0]     sine_idx;

    assign tsel = tst_e'(test_sel);

    lfsr_scrambler #(.LEN(17), .TAP_HI(16), .TAP_LO(11)) scr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (scr_step),
        .din   (nsym),
        .dout  (scr_out)
    );

    tone_phase_acc #(.PW(PHASE_W), .IW(IW)) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (acc_adv),
        .inc   (acc_inc),
        .idx   (sine_idx)
    );

    always_comb begin
        st_d     = st_q;
        bit_take = 1'b0;
        scr_step = 1'b0;
        nsym     = bit_in ? st_q.sym : ~st_q.sym;
        acc_adv  = sample_en & ~baseband_mode;
        acc_inc  = st_q.tone ? space_inc : mark_inc;

        if (baud_tick) begin
            unique case (tsel)
                TST_OFF: begin
                    bit_take = 1'b1;
                    st_d.sym = nsym;
                    if (baseband_mode) begin
                        scr_step  = 1'b1;
                        st_d.line = scr_out;
                    end else begin
                        st_d.tone = nsym;
                    end
                end
                TST_MARK: begin
                    if (baseband_mode) st_d.line = 1'b0;
                    else               st_d.tone = 1'b0;
                end
                TST_SPACE: begin
                    if (baseband_mode) st_d.line = 1'b1;
                    else               st_d.tone = 1'b1;
                end
                TST_ALT: begin
                    if (baseband_mode) begin
                        st_d.line = ~st_q.line;
                    end else begin
                        st_d.sym  = ~st_q.sym;
                        st_d.tone = ~st_q.sym;
                    end
                end
                default: ;
            endcase
        end

        if (sample_en)
            st_d.dac = baseband_mode ? {DAC_W{st_q.line}} : sine_level(sine_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sym: 1'b0, line: 1'b0, tone: 1'b0, dac: DAC_MID};
        else        st_q <= st_d;
    end

    assign dac_code = st_q.dac;

    // R1: NRZI encoding of consumed bits
    assert_nrzi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && tsel == TST_OFF && !bit_in) |=> st_q.sym != $past(st_q.sym));
    assert_nrzi_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && tsel == TST_OFF && bit_in) |=> $stable(st_q.sym));
    // R2: no bit is taken outside a tick
    assert_take_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |-> !bit_take);
    // R7: output holds between samples; baseband has two levels
    assert_dac_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(dac_code));
    assert_bb_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && baseband_mode) |=> (dac_code == '0 || dac_code == '1));
    // R6: tone samples stay within 1..15
    assert_tone_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !baseband_mode) |=> (dac_code != '0));
    // R8: steady tests force the tone select
    assert_steady_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && !baseband_mode && tsel == TST_MARK) |=> !st_q.tone);
    assert_steady_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && !baseband_mode && tsel == TST_SPACE) |=> st_q.tone);
    // R9: alternating baseband test flips the line level
    assert_alt_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && baseband_mode && tsel == TST_ALT) |=> st_q.line != $past(st_q.line));

endmodule

// File: tb/tone_bb_tx_gen_tb.sv
`timescale 1ns/1ps
module tone_bb_tx_gen_tb_top;

    localparam int PW = 12;
    localparam logic [PW-1:0] MK = 12'd32;
    localparam logic [PW-1:0] SP = 12'd96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          baud_tick = 1'b0;
    logic          sample_en = 1'b0;
    logic          baseband_mode = 1'b0;
    logic [1:0]    test_sel = 2'd0;
    logic          bit_in = 1'b0;
    logic          bit_take;
    logic [3:0]    dac_code;

    always #2.5 clk = ~clk;

    tone_bb_tx_gen #(.PHASE_W(PW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .baud_tick     (baud_tick),
        .sample_en     (sample_en),
        .baseband_mode (baseband_mode),
        .test_sel      (test_sel),
        .mark_inc      (MK),
        .space_inc     (SP),
        .bit_in        (bit_in),
        .bit_take      (bit_take),
        .dac_code      (dac_code)
    );

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    exp_t    sb_q[$];
    int      n_cmp = 0;
    int      n_bad = 0;

    // reference state, kept from the requirements
    logic          m_sym = 1'b0;
    logic          m_line = 1'b0;
    logic          m_tone = 1'b0;
    logic [16:0]   m_reg = '1;
    logic [PW-1:0] m_ph = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ref_sine(input int i);
        real s;
        s = $sin(2.0 * 3.14159265358979 * real'(i) / 128.0);
        if (s < 0.0) s = -s;
        if (i < 64) return int'($floor(8.0 + 7.0 * s + 1.0e-9));
        return 16 - int'($floor(8.0 + 7.0 * s + 1.0e-9));
    endfunction

    // driver: one clock cycle of stimulus, model update and scoreboard push
    task automatic step(input bit bt, input bit se, input bit b, input string tag);
        logic ns;
        logic tx;
        exp_t e;
        @(negedge clk);
        baud_tick = bt;
        sample_en = se;
        bit_in    = b;
        if (se) begin
            e.tag = tag;
            if (baseband_mode) e.val = m_line ? 15 : 0;
            else begin
                e.val = ref_sine(int'(m_ph[PW-1 -: 7]));
                m_ph  = m_ph + (m_tone ? SP : MK);
            end
            sb_q.push_back(e);
        end
        if (bt) begin
            ns = b ? m_sym : ~m_sym;
            case (test_sel)
                2'd0: begin
                    m_sym = ns;
                    if (baseband_mode) begin
                        tx     = ns ^ m_reg[16] ^ m_reg[11];
                        m_reg  = {m_reg[15:0], tx};
                        m_line = tx;
                    end else m_tone = ns;
                end
                2'd1: if (baseband_mode) m_line = 1'b0; else m_tone = 1'b0;
                2'd2: if (baseband_mode) m_line = 1'b1; else m_tone = 1'b1;
                default: if (baseband_mode) m_line = ~m_line;
                         else begin m_sym = ~m_sym; m_tone = m_sym; end
            endcase
        end
        #1;
        if (bt) chk(bit_take == (test_sel == 2'd0), (test_sel == 2'd0) ? "R1 bit_take" : "R2 bit_take",
                    int'(bit_take), int'(test_sel == 2'd0));
        else    chk(bit_take == 1'b0, "R2 bit_take idle", int'(bit_take), 0);
        @(posedge clk);
        #1;
    endtask

    // monitor: compares each sample result one edge after its sample_en
    initial begin
        forever begin
            @(posedge clk);
            if (sample_en && rst_n) begin
                #1;
                if (sb_q.size() == 0) chk(1'b0, "scoreboard empty", int'(dac_code), -1);
                else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(int'(dac_code) == e.val, e.tag, int'(dac_code), e.val);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values at the ports
        chk(dac_code == 4'd8, "R10 dac after reset", int'(dac_code), 8);
        chk(bit_take == 1'b0, "R10 bit_take after reset", int'(bit_take), 0);

        // tone mode, mixed data, five samples per bit; R1 R4 R5 R6
        begin
            bit pat [8] = '{1, 0, 0, 1, 1, 0, 1, 0};
            foreach (pat[i]) begin
                step(1'b1, 1'b0, pat[i], "R1 R4 tone");
                for (int j = 0; j < 5; j++) step(1'b0, 1'b1, 1'b0, "R4 R6 tone sample");
            end
        end
        // R11: test select changes between ticks do nothing
        test_sel = 2'd2;
        for (int j = 0; j < 6; j++) step(1'b0, 1'b1, 1'b0, "R11 test_sel ignored");
        // R8 steady space then steady mark, bits offered but not taken
        step(1'b1, 1'b1, 1'b0, "R8 space tick");
        for (int j = 0; j < 6; j++) step(1'b0, 1'b1, 1'b0, "R8 steady space");
        test_sel = 2'd1;
        step(1'b1, 1'b0, 1'b0, "R8 mark tick");
        for (int j = 0; j < 6; j++) step(1'b0, 1'b1, 1'b0, "R8 steady mark");
        // R9 alternating symbols
        test_sel = 2'd3;
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 1'b0, 1'b1, "R9 alt tick");
            for (int j = 0; j < 3; j++) step(1'b0, 1'b1, 1'b0, "R9 alt tone");
        end
        // long run across the table wrap, with tick and sample in the same cycle; R5
        test_sel = 2'd0;
        for (int k = 0; k < 300; k++)
            step((k % 8) == 0, 1'b1, (k % 24) < 8, "R5 wrap");

        // baseband from the all-ones register; R3 R7
        baseband_mode = 1'b1;
        for (int k = 0; k < 40; k++) begin
            step(1'b1, 1'b0, (k % 5) != 2, "R3 bb tick");
            step(1'b0, 1'b1, 1'b0, "R3 R7 bb level");
        end
        for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 1'b1, "R3 R7 bb tick+sample");
        // baseband tests
        test_sel = 2'd2;
        step(1'b1, 1'b0, 1'b0, "R8 bb space tick");
        step(1'b0, 1'b1, 1'b0, "R8 bb space");
        test_sel = 2'd1;
        step(1'b1, 1'b0, 1'b0, "R8 bb mark tick");
        step(1'b0, 1'b1, 1'b0, "R8 bb mark");
        test_sel = 2'd3;
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 1'b0, 1'b0, "R9 bb alt tick");
            step(1'b0, 1'b1, 1'b0, "R9 bb alt");
        end
        // scrambler resumes where it stopped; R3 R8
        test_sel = 2'd0;
        for (int k = 0; k < 20; k++) begin
            step(1'b1, 1'b0, (k % 3) == 0, "R3 bb resume");
            step(1'b0, 1'b1, 1'b0, "R3 bb resume level");
        end
        // back to tone mode, phase held over baseband; R5
        baseband_mode = 1'b0;
        for (int j = 0; j < 10; j++) step(1'b0, 1'b1, 1'b0, "R5 phase kept");
        step(1'b0, 1'b0, 1'b0, "R7 idle");
        step(1'b0, 1'b0, 1'b0, "R7 idle");
        chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule